// File: doc/BRIEF.md
# Host-Protected-Area Max-Address Lock Controller

This block tracks the command state that guards the user-visible capacity of a storage device. A host command decoder hands it one event at a time. Each event is a native-maximum read, a max-address set or one of four lock subcommands: password-set, lock, unlock and freeze. Power-on, through `rst_n`, and the interface hard reset also reach the block. It answers every event one cycle later with a result pulse, an abort flag and the status and error bytes that the host will read. It also holds the maximum LBA that the rest of the device must honour.

A max-address set succeeds only under three conditions. The command just before it must be a native-maximum read. The lock machine must be open. A volatile set may happen only once between resets. Password storage and comparison live elsewhere, and the result of that comparison arrives on `pw_match`. A non-volatile set writes a persistent copy. A volatile set changes only the live value, and the live value falls back to the persistent copy on every hard reset.

Top module: `mla_lock_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, the following values hold: `lock_state` is open (0), `max_lba` equals `native_max`, `done` and `aborted` are 0, `status_code` is 50h and `error_code` is 00h.
- R2: A max-address set (op 1) is aborted unless the previous accepted event was a native-maximum read (op 0). Any other event in between clears the permission, even an aborted one.
- R3: A volatile max-address set (`cmd_volatile`=1) is accepted at most once between resets. A second volatile set is aborted. A hard reset allows a volatile set again.
- R4: A max-address set issued while `lock_state` is locked (1) or frozen (2) is aborted, with `status_code` 51h and `error_code` 04h.
- R5: An accepted max-address set makes `max_lba` equal `cmd_addr` in the cycle after the command. An address above `native_max` is aborted and leaves `max_lba` unchanged.
- R6: Lock (op 3) moves the state from open to locked. Unlock (op 4) returns it to open only when `pw_match` is 1. An unlock with a mismatch is aborted and the state stays locked. Unlock in any other state is aborted.
- R7: Freeze (op 5) moves the state from open or locked to frozen (2). In the frozen state, password-set, lock, unlock, freeze and max-address set are all aborted, and only a reset leaves the frozen state.
- R8: A hard reset restores `max_lba` to the value of the last non-volatile set, or to `native_max` if there was none. It also returns `lock_state` to open.
- R9: `done` is high for exactly the one cycle after each accepted `cmd_valid`. An accepted command sets `aborted`=0, `status_code` 50h and `error_code` 00h. An aborted command sets `aborted`=1, 51h and 04h.
- R10: Password-set (op 2) is accepted only in the open state and does not change `lock_state`.
- R11: When `hard_reset` and `cmd_valid` are high in the same cycle, the reset takes effect and the command is dropped, so `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| hard_reset | input | 1 | Interface hard reset, one-cycle pulse |
| cmd_valid | input | 1 | Command event strobe |
| cmd_op | input | 3 | Event code: 0 native read, 1 set max, 2 password set, 3 lock, 4 unlock, 5 freeze, 6 other |
| cmd_volatile | input | 1 | Volatile flag of a max-address set |
| cmd_addr | input | LBA_W | Requested maximum LBA |
| pw_match | input | 1 | Password comparison result for unlock |
| native_max | input | LBA_W | Native capacity of the medium |
| max_lba | output | LBA_W | Active user-visible maximum LBA |
| done | output | 1 | Result pulse |
| aborted | output | 1 | The last command was aborted |
| status_code | output | 8 | Status byte of the last command |
| error_code | output | 8 | Error byte of the last command |
| lock_state | output | 2 | 0 open, 1 locked, 2 frozen |

## Verification
The bound checker enforces the following on every cycle:
- the result pulse follows each command;
- abort codes pair with the abort flag;
- the frozen state persists until a reset;
- a max-address set in a locked state or without a preceding native read is aborted;
- the maximum LBA moves only on an accepted command or a hard reset.

Some properties need history across several commands, and only the bench's scenarios can show them:
- the volatile set is allowed once per reset window;
- the persistent value is restored after a volatile set;
- a password mismatch keeps the lock;
- a reset that collides with a command drops the command.

// File: rtl/mla_pkg.sv
package mla_pkg;
   typedef enum logic [2:0] {
      OP_RD_NATIVE = 3'd0,
      OP_SET_MAX   = 3'd1,
      OP_SET_PW    = 3'd2,
      OP_LOCK      = 3'd3,
      OP_UNLOCK    = 3'd4,
      OP_FREEZE    = 3'd5,
      OP_OTHER     = 3'd6
   } mla_op_e;

   typedef enum logic [1:0] {
      ST_OPEN   = 2'd0,
      ST_LOCKED = 2'd1,
      ST_FROZEN = 2'd2
   } mla_state_e;

   localparam logic [7:0] STAT_OK    = 8'h50;
   localparam logic [7:0] STAT_ABORT = 8'h51;
   localparam logic [7:0] ERR_NONE   = 8'h00;
   localparam logic [7:0] ERR_ABRT   = 8'h04;
endpackage

// File: rtl/mla_cmd_decide.sv
module mla_cmd_decide
   import mla_pkg::*;
#(
   parameter int LBA_W      = 28,
   parameter bit CLAMP_ADDR = 1'b0
) (
   input  logic [2:0]       op,
   input  mla_state_e       state,
   input  logic             just_read,
   input  logic             vol_used,
   input  logic             vol,
   input  logic [LBA_W-1:0] addr,
   input  logic [LBA_W-1:0] native,
   input  logic             pw_match,
   output logic             accept,
   output mla_state_e       next_state,
   output logic             load_max,
   output logic             load_nv,
   output logic             take_vol,
   output logic [LBA_W-1:0] new_max
);
   logic over_native;
   logic range_ok;
   logic set_ok;

   assign over_native = (addr > native);

   generate
      if (CLAMP_ADDR) begin : g_clamp
         assign range_ok = 1'b1;
         assign new_max  = over_native ? native : addr;
      end else begin : g_strict
         assign range_ok = ~over_native;
         assign new_max  = addr;
      end
   endgenerate

   assign set_ok = just_read && (state == ST_OPEN) && !(vol && vol_used) && range_ok;

   always_comb begin
      accept     = 1'b0;
      next_state = state;
      load_max   = 1'b0;
      load_nv    = 1'b0;
      take_vol   = 1'b0;
      case (op)
         OP_RD_NATIVE: accept = 1'b1;
         OP_SET_MAX: begin
            accept   = set_ok;
            load_max = set_ok;
            load_nv  = set_ok && !vol;
            take_vol = set_ok && vol;
         end
         OP_SET_PW: accept = (state == ST_OPEN);
         OP_LOCK: begin
            accept = (state != ST_FROZEN);
            if (state != ST_FROZEN) next_state = ST_LOCKED;
         end
         OP_UNLOCK: begin
            accept = (state == ST_LOCKED) && pw_match;
            if ((state == ST_LOCKED) && pw_match) next_state = ST_OPEN;
         end
         OP_FREEZE: begin
            accept     = (state != ST_FROZEN);
            next_state = ST_FROZEN;
         end
         default: accept = 1'b1;
      endcase
   end
endmodule

// File: rtl/mla_lock_fsm.sv
module mla_lock_fsm
   import mla_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hard_reset,
   input  logic       fire,
   input  logic       op_is_read,
   input  mla_state_e next_state,
   input  logic       take_vol,
   output mla_state_e state,
   output logic       just_read,
   output logic       vol_used
);
   always_ff @(posedge clk) begin
      if (!rst_n || hard_reset) begin
         state     <= ST_OPEN;
         just_read <= 1'b0;
         vol_used  <= 1'b0;
      end else if (fire) begin
         state     <= next_state;
         just_read <= op_is_read;
         if (take_vol) vol_used <= 1'b1;
      end
   end
endmodule

// File: rtl/mla_addr_store.sv
module mla_addr_store #(
   parameter int LBA_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hard_reset,
   input  logic [LBA_W-1:0] native,
   input  logic             load_max,
   input  logic             load_nv,
   input  logic [LBA_W-1:0] new_max,
   output logic [LBA_W-1:0] max_lba
);
   logic [LBA_W-1:0] nv_max;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nv_max  <= native;
         max_lba <= native;
      end else if (hard_reset) begin
         max_lba <= nv_max;
      end else begin
         if (load_nv)  nv_max  <= new_max;
         if (load_max) max_lba <= new_max;
      end
   end
endmodule

// File: rtl/mla_lock_ctrl.sv
module mla_lock_ctrl
   import mla_pkg::*;
#(
   parameter int LBA_W      = 28,
   parameter bit CLAMP_ADDR = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hard_reset,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_op,
   input  logic             cmd_volatile,
   input  logic [LBA_W-1:0] cmd_addr,
   input  logic             pw_match,
   input  logic [LBA_W-1:0] native_max,
   output logic [LBA_W-1:0] max_lba,
   output logic             done,
   output logic             aborted,
   output logic [7:0]       status_code,
   output logic [7:0]       error_code,
   output logic [1:0]       lock_state
);
   generate
      if (LBA_W < 8 || LBA_W > 48) begin : g_bad_width
         $error("mla_lock_ctrl: LBA_W must lie in 8..48");
      end
   endgenerate

   logic             fire;
   logic             accept;
   logic             load_max;
   logic             load_nv;
   logic             take_vol;
   logic             just_read;
   logic             vol_used;
   logic [LBA_W-1:0] new_max;
   mla_state_e       state;
   mla_state_e       next_state;

   assign fire       = cmd_valid & ~hard_reset;
   assign lock_state = state;

   mla_cmd_decide #(.LBA_W(LBA_W), .CLAMP_ADDR(CLAMP_ADDR)) u_decide (
      .op(cmd_op), .state(state), .just_read(just_read), .vol_used(vol_used),
      .vol(cmd_volatile), .addr(cmd_addr), .native(native_max), .pw_match(pw_match),
      .accept(accept), .next_state(next_state), .load_max(load_max),
      .load_nv(load_nv), .take_vol(take_vol), .new_max(new_max)
   );

   mla_lock_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .hard_reset(hard_reset), .fire(fire),
      .op_is_read(cmd_op == OP_RD_NATIVE), .next_state(next_state),
      .take_vol(take_vol), .state(state), .just_read(just_read), .vol_used(vol_used)
   );

   mla_addr_store #(.LBA_W(LBA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .hard_reset(hard_reset), .native(native_max),
      .load_max(fire & load_max), .load_nv(fire & load_nv), .new_max(new_max),
      .max_lba(max_lba)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done        <= 1'b0;
         aborted     <= 1'b0;
         status_code <= STAT_OK;
         error_code  <= ERR_NONE;
      end else begin
         done <= fire;
         if (fire) begin
            aborted     <= ~accept;
            status_code <= accept ? STAT_OK : STAT_ABORT;
            error_code  <= accept ? ERR_NONE : ERR_ABRT;
         end
      end
   end
endmodule

// File: rtl/mla_lock_checker.sv
module mla_lock_checker
   import mla_pkg::*;
#(
   parameter int LBA_W = 28
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hard_reset,
   input logic             cmd_valid,
   input logic [2:0]       cmd_op,
   input logic [LBA_W-1:0] max_lba,
   input logic             done,
   input logic             aborted,
   input logic [7:0]       status_code,
   input logic [7:0]       error_code,
   input logic [1:0]       lock_state
);
   logic prev_rd;

   always_ff @(posedge clk) begin
      if (!rst_n || hard_reset) prev_rd <= 1'b0;
      else if (cmd_valid)       prev_rd <= (cmd_op == OP_RD_NATIVE);
   end

   assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !hard_reset) |=> done);

   assert_no_stray_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && !hard_reset) |=> !done);

   assert_abort_codes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && aborted) |-> (status_code == STAT_ABORT && error_code == ERR_ABRT));

   assert_need_native_read_R2: assert property (@(posedge clk) disable iff (!rst_n || hard_reset)
      (cmd_valid && cmd_op == OP_SET_MAX && !prev_rd) |=> aborted);

   assert_locked_set_aborts_R4: assert property (@(posedge clk) disable iff (!rst_n || hard_reset)
      (cmd_valid && cmd_op == OP_SET_MAX && lock_state != ST_OPEN) |=> aborted);

   assert_frozen_sticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_state == ST_FROZEN && !hard_reset) |=> lock_state == ST_FROZEN);

   assert_max_moves_legally_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(max_lba) |-> ($past(hard_reset) || (done && !aborted)));
endmodule

bind mla_lock_ctrl mla_lock_checker #(.LBA_W(LBA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hard_reset(hard_reset), .cmd_valid(cmd_valid),
   .cmd_op(cmd_op), .max_lba(max_lba), .done(done), .aborted(aborted),
   .status_code(status_code), .error_code(error_code), .lock_state(lock_state)
);

// File: tb/sim_mla_lock_ctrl.sv
`timescale 1ns/1ps
module sim_mla_lock_ctrl;
   localparam int LBA_W = 28;
   localparam logic [LBA_W-1:0] NATIVE = 28'h0A0_0000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             hard_reset = 1'b0;
   logic             cmd_valid = 1'b0;
   logic [2:0]       cmd_op = 3'd6;
   logic             cmd_volatile = 1'b0;
   logic [LBA_W-1:0] cmd_addr = '0;
   logic             pw_match = 1'b0;
   logic [LBA_W-1:0] max_lba;
   logic             done, aborted;
   logic [7:0]       status_code, error_code;
   logic [1:0]       lock_state;

   int n_vec = 0;
   int n_bad = 0;

   logic [1:0]       m_st;
   logic             m_just, m_vused, m_abort;
   logic [LBA_W-1:0] m_max, m_nv;

   always #2 clk = ~clk;

   mla_lock_ctrl #(.LBA_W(LBA_W)) u0 (
      .clk(clk), .rst_n(rst_n), .hard_reset(hard_reset), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_volatile(cmd_volatile), .cmd_addr(cmd_addr),
      .pw_match(pw_match), .native_max(NATIVE), .max_lba(max_lba), .done(done),
      .aborted(aborted), .status_code(status_code), .error_code(error_code),
      .lock_state(lock_state)
   );

   function automatic string tag_of(input logic [2:0] op);
      case (op)
         3'd0: return "R9";
         3'd1: return "R2";
         3'd2: return "R10";
         3'd3: return "R6";
         3'd4: return "R6";
         3'd5: return "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic model_reset_hard();
      m_st = 2'd0; m_just = 1'b0; m_vused = 1'b0; m_max = m_nv;
   endtask

   task automatic model_cmd(input logic [2:0] op, input logic vol,
                            input logic [LBA_W-1:0] addr, input logic pm);
      logic acc;
      acc = 1'b1;
      case (op)
         3'd1: begin
            acc = m_just && (m_st == 2'd0) && !(vol && m_vused) && (addr <= NATIVE);
            if (acc) begin
               m_max = addr;
               if (vol) m_vused = 1'b1; else m_nv = addr;
            end
         end
         3'd2: acc = (m_st == 2'd0);
         3'd3: begin acc = (m_st != 2'd2); if (acc) m_st = 2'd1; end
         3'd4: begin acc = (m_st == 2'd1) && pm; if (acc) m_st = 2'd0; end
         3'd5: begin acc = (m_st != 2'd2); m_st = 2'd2; end
         default: acc = 1'b1;
      endcase
      m_just  = (op == 3'd0);
      m_abort = !acc;
   endtask

   task automatic check_all(input string tag, input logic exp_done);
      logic [7:0] es, ee;
      es = m_abort ? 8'h51 : 8'h50;
      ee = m_abort ? 8'h04 : 8'h00;
      n_vec++;
      if (done !== exp_done || (exp_done && (aborted !== m_abort || status_code !== es ||
          error_code !== ee)) || max_lba !== m_max || lock_state !== m_st) begin
         n_bad++;
         $display("FAIL %s: got done=%0b abort=%0b st=%h err=%h max=%h lock=%0d, exp done=%0b abort=%0b st=%h err=%h max=%h lock=%0d",
                  tag, done, aborted, status_code, error_code, max_lba, lock_state,
                  exp_done, m_abort, es, ee, m_max, m_st);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic vol,
                        input logic [LBA_W-1:0] addr, input logic pm, input string tag);
      cmd_valid = 1'b1; cmd_op = op; cmd_volatile = vol; cmd_addr = addr; pw_match = pm;
      model_cmd(op, vol, addr, pm);
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      check_all(tag, 1'b1);
   endtask

   task automatic pulse_hard(input logic with_cmd, input string tag);
      hard_reset = 1'b1;
      cmd_valid = with_cmd; cmd_op = 3'd3;
      model_reset_hard();
      @(posedge clk);
      @(negedge clk);
      hard_reset = 1'b0; cmd_valid = 1'b0;
      check_all(tag, 1'b0);
   endtask

   initial begin
      #(4.0 * 200000);
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout, exp finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      m_nv = NATIVE; m_abort = 1'b0;
      model_reset_hard();
      repeat (3) @(negedge clk);
      check_all("R1 during reset", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after reset", 1'b0);

      issue(3'd1, 0, 28'h100, 0, "R2 set without read");
      issue(3'd0, 0, 0, 0, "R2 read");
      issue(3'd6, 0, 0, 0, "R2 other");
      issue(3'd1, 0, 28'h100, 0, "R2 intervening cmd");
      issue(3'd0, 0, 0, 0, "R5 read");
      issue(3'd1, 0, 28'h100, 0, "R5 accepted set");
      issue(3'd0, 0, 0, 0, "R5 read");
      issue(3'd1, 0, NATIVE + 1, 0, "R5 above native");
      issue(3'd0, 0, 0, 0, "R5 read");
      issue(3'd1, 0, NATIVE, 0, "R5 equal native");
      issue(3'd0, 0, 0, 0, "R5 read");
      issue(3'd1, 0, 28'h100, 0, "R5 back to 100h");
      issue(3'd0, 0, 0, 0, "R3 read");
      issue(3'd1, 1, 28'h80, 0, "R3 first volatile");
      issue(3'd0, 0, 0, 0, "R3 read");
      issue(3'd1, 1, 28'h90, 0, "R3 second volatile");
      pulse_hard(0, "R8 volatile reverts");
      issue(3'd0, 0, 0, 0, "R3 read");
      issue(3'd1, 1, 28'h70, 0, "R3 volatile after reset");
      issue(3'd2, 0, 0, 0, "R10 pw set open");
      issue(3'd3, 0, 0, 0, "R6 lock");
      issue(3'd0, 0, 0, 0, "R4 read");
      issue(3'd1, 0, 28'h50, 0, "R4 set while locked");
      issue(3'd2, 0, 0, 0, "R10 pw set locked");
      issue(3'd4, 0, 0, 0, "R6 unlock mismatch");
      issue(3'd4, 0, 0, 1, "R6 unlock match");
      issue(3'd5, 0, 0, 0, "R7 freeze");
      issue(3'd3, 0, 0, 0, "R7 lock frozen");
      issue(3'd4, 0, 0, 1, "R7 unlock frozen");
      issue(3'd5, 0, 0, 0, "R7 freeze frozen");
      issue(3'd2, 0, 0, 0, "R7 pw frozen");
      issue(3'd0, 0, 0, 0, "R4 read");
      issue(3'd1, 0, 28'h40, 0, "R4 set while frozen");
      pulse_hard(0, "R7 reset leaves frozen");
      pulse_hard(1, "R11 reset beats command");

      for (int i = 0; i < 1500; i++) begin
         logic [2:0] op;
         logic [LBA_W-1:0] a;
         if (($urandom % 40) == 0) begin
            pulse_hard(0, "R8 random hard reset");
         end else begin
            op = 3'($urandom % 7);
            if (($urandom % 3) == 0) op = 3'd0;
            a = (($urandom % 8) == 0) ? NATIVE + LBA_W'($urandom % 16)
                                      : LBA_W'($urandom % (NATIVE + 1));
            issue(op, 1'($urandom % 2), a, 1'($urandom % 2), tag_of(op));
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule